// File: doc/BRIEF.md
# Hypervisor Virtual Interrupt Pending and Enable Registers

This block holds three control registers of a hypervisor-capable processor: a virtual-interrupt-pending register that hypervisor software writes to inject interrupts into a guest, a hypervisor interrupt-pending register, and a hypervisor interrupt-enable register. Each register is XLEN bits wide. Only the low sixteen bits have defined fields. Every bit above bit 15 always reads as zero.

Software reaches the registers through a single-cycle port. A 2-bit select picks the register. A read returns the current value combinationally in the same cycle. A write is captured at the clock edge and shows on a read from the next cycle onward. Several pending bits are not stored. They are formed every cycle from the stored bits and from external lines: the guest-external pending and enable vectors, a guest-external selector, a platform guest-level external interrupt line and a guest timer line. The composed pending and enable vectors drive the trap logic directly.

Top module: `hv_irq_regs`

## Requirements
- R1: After reset, every stored bit is zero. With all external inputs low, every register reads zero and `pend_out` and `en_out` are zero.
- R2: Writing the virtual-pending register (select 0) keeps only bits 2, 6 and 10 of the write data. Reads of select 0 in the next cycle show exactly those bits, and every other bit reads zero.
- R3: Bit 12 of the hypervisor pending value (select 1, and `pend_out`) is 1 exactly when `gext_pend & gext_en` has at least one bit set. Writes cannot change it.
- R4: Bit 10 of the hypervisor pending value is the OR of three sources: stored virtual-pending bit 10, the guest-external line chosen by `guest_sel`, and `plat_vsext`. Writes to select 1 cannot change it.
- R5: A `guest_sel` value k with 1 <= k <= GEILEN selects `gext_pend[k-1]`. A value of 0, or any value above GEILEN, selects nothing and contributes 0.
- R6: Bit 6 of the hypervisor pending value is stored virtual-pending bit 6 OR `vs_timer`. Writes to select 1 cannot change it.
- R7: Bit 2 of the hypervisor pending value reads stored virtual-pending bit 2. A write to select 1 copies write-data bit 2 into that stored bit, which then also reads back through select 0.
- R8: Writing the enable register (select 2) keeps only bits 2, 6, 10 and 12. These bits read back through select 2 in the next cycle.
- R9: Bits 1, 5 and 9, which belong to the supervisor-level registers, and every other bit outside the defined fields, read as zero in all three registers. Select 3 always reads zero, and a write to select 3 changes no stored bit.
- R10: `pend_out` always equals the select-1 read value, and `en_out` always equals the select-2 read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_sel | input | 2 | Register select: 0 virtual-pending, 1 hypervisor pending, 2 hypervisor enable, 3 none |
| acc_we | input | 1 | Write strobe for the selected register |
| acc_wdata | input | XLEN | Write data |
| acc_rdata | output | XLEN | Read data of the selected register, same cycle |
| gext_pend | input | GEILEN | Guest-external pending lines; bit k-1 is line k |
| gext_en | input | GEILEN | Guest-external enable lines |
| guest_sel | input | SEL_W | Guest-external line selector for the guest external interrupt |
| plat_vsext | input | 1 | Platform guest-level external interrupt |
| vs_timer | input | 1 | Guest-level timer interrupt line |
| pend_out | output | XLEN | Composed hypervisor pending vector to trap logic |
| en_out | output | XLEN | Hypervisor enable vector to trap logic |

## Verification
The bench writes every single-bit pattern into each register. A design that stores a wrong bit, or lets a supervisor-owned bit through, shows a nonzero reserved bit on readback. It sweeps every selector value against every one-hot pending pattern, which catches off-by-one line indexing and a selector of 0 or above GEILEN that wrongly picks a line. It also runs all pending/enable pairs through the guest summary bit, where a design that used OR in place of AND would report false interrupts. Writes of all ones and all zeros to the hypervisor pending register show whether the derived bits can wrongly be cleared or set by software, and whether the software-interrupt alias fails to reach the stored bit.

// File: rtl/hv_irq_pkg.sv
package hv_irq_pkg;
    localparam int BIT_VSS = 2;
    localparam int BIT_VST = 6;
    localparam int BIT_VSE = 10;
    localparam int BIT_SGE = 12;

    typedef enum logic [1:0] {
        RS_VPEND = 2'd0,
        RS_HPEND = 2'd1,
        RS_HEN   = 2'd2,
        RS_NONE  = 2'd3
    } regsel_e;

    typedef struct packed {
        logic vse;
        logic vst;
        logic vss;
    } vip_t;

    typedef struct packed {
        logic sge;
        logic vse;
        logic vst;
        logic vss;
    } hen_t;

    typedef struct packed {
        vip_t vip;
        hen_t hen;
    } store_t;
endpackage

// File: rtl/hv_irq_store.sv
module hv_irq_store
    import hv_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   we,
    input  logic [1:0] sel,
    input  logic [15:0] wbits,
    output store_t st
);
    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            case (regsel_e'(sel))
                RS_VPEND: st_d.vip = {wbits[BIT_VSE], wbits[BIT_VST], wbits[BIT_VSS]};
                RS_HPEND: st_d.vip.vss = wbits[BIT_VSS];
                RS_HEN:   st_d.hen = {wbits[BIT_SGE], wbits[BIT_VSE], wbits[BIT_VST], wbits[BIT_VSS]};
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/hv_irq_compose.sv
module hv_irq_compose
    import hv_irq_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int GEILEN = 6,
    parameter int SEL_W  = 6
) (
    input  store_t            st,
    input  logic [GEILEN-1:0] gext_pend,
    input  logic [GEILEN-1:0] gext_en,
    input  logic [SEL_W-1:0]  guest_sel,
    input  logic              plat_vsext,
    input  logic              vs_timer,
    output logic [XLEN-1:0]   vip_view,
    output logic [XLEN-1:0]   hip_view,
    output logic [XLEN-1:0]   hie_view
);
    logic sel_hit;
    logic sgei;

    always_comb begin
        sel_hit = 1'b0;
        for (int k = 1; k <= GEILEN; k++) begin
            if (guest_sel == SEL_W'(k)) sel_hit = sel_hit | gext_pend[k-1];
        end
        sgei = |(gext_pend & gext_en);
    end

    always_comb begin
        vip_view = '0;
        vip_view[BIT_VSS] = st.vip.vss;
        vip_view[BIT_VST] = st.vip.vst;
        vip_view[BIT_VSE] = st.vip.vse;

        hip_view = '0;
        hip_view[BIT_VSS] = st.vip.vss;
        hip_view[BIT_VST] = st.vip.vst | vs_timer;
        hip_view[BIT_VSE] = st.vip.vse | sel_hit | plat_vsext;
        hip_view[BIT_SGE] = sgei;

        hie_view = '0;
        hie_view[BIT_VSS] = st.hen.vss;
        hie_view[BIT_VST] = st.hen.vst;
        hie_view[BIT_VSE] = st.hen.vse;
        hie_view[BIT_SGE] = st.hen.sge;
    end
endmodule

// File: rtl/hv_irq_readmux.sv
module hv_irq_readmux
    import hv_irq_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [1:0]      sel,
    input  logic [XLEN-1:0] vip_view,
    input  logic [XLEN-1:0] hip_view,
    input  logic [XLEN-1:0] hie_view,
    output logic [XLEN-1:0] rdata
);
    always_comb begin
        case (regsel_e'(sel))
            RS_VPEND: rdata = vip_view;
            RS_HPEND: rdata = hip_view;
            RS_HEN:   rdata = hie_view;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/hv_irq_regs.sv
module hv_irq_regs
    import hv_irq_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int GEILEN = 6,
    parameter int SEL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        acc_sel,
    input  logic              acc_we,
    input  logic [XLEN-1:0]   acc_wdata,
    output logic [XLEN-1:0]   acc_rdata,
    input  logic [GEILEN-1:0] gext_pend,
    input  logic [GEILEN-1:0] gext_en,
    input  logic [SEL_W-1:0]  guest_sel,
    input  logic              plat_vsext,
    input  logic              vs_timer,
    output logic [XLEN-1:0]   pend_out,
    output logic [XLEN-1:0]   en_out
);
    store_t          st;
    logic [XLEN-1:0] vip_view, hip_view, hie_view;
    logic            unused_wbits;

    assign unused_wbits = ^acc_wdata;

    hv_irq_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (acc_we),
        .sel   (acc_sel),
        .wbits (acc_wdata[15:0]),
        .st    (st)
    );

    hv_irq_compose #(.XLEN(XLEN), .GEILEN(GEILEN), .SEL_W(SEL_W)) u_compose (
        .st         (st),
        .gext_pend  (gext_pend),
        .gext_en    (gext_en),
        .guest_sel  (guest_sel),
        .plat_vsext (plat_vsext),
        .vs_timer   (vs_timer),
        .vip_view   (vip_view),
        .hip_view   (hip_view),
        .hie_view   (hie_view)
    );

    hv_irq_readmux #(.XLEN(XLEN)) u_rmux (
        .sel      (acc_sel),
        .vip_view (vip_view),
        .hip_view (hip_view),
        .hie_view (hie_view),
        .rdata    (acc_rdata)
    );

    assign pend_out = hip_view;
    assign en_out   = hie_view;
endmodule

// File: rtl/hv_irq_regs_chk.sv
module hv_irq_regs_chk #(
    parameter int XLEN   = 64,
    parameter int GEILEN = 6,
    parameter int SEL_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        acc_sel,
    input logic              acc_we,
    input logic [XLEN-1:0]   acc_wdata,
    input logic [XLEN-1:0]   acc_rdata,
    input logic [GEILEN-1:0] gext_pend,
    input logic [GEILEN-1:0] gext_en,
    input logic [SEL_W-1:0]  guest_sel,
    input logic              plat_vsext,
    input logic              vs_timer,
    input logic [XLEN-1:0]   pend_out,
    input logic [XLEN-1:0]   en_out
);
    localparam logic [XLEN-1:0] HIP_MASK = XLEN'(16'h1444);
    localparam logic [XLEN-1:0] HIE_MASK = XLEN'(16'h1444);
    localparam logic [XLEN-1:0] VIP_MASK = XLEN'(16'h0444);

    p_vpend_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && acc_sel == 2'd0) |=> (pend_out[2] == $past(acc_wdata[2])));

    p_vpend_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel == 2'd0) |-> ((acc_rdata & ~VIP_MASK) == '0));

    p_sgei_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pend_out[12] == (|(gext_pend & gext_en)));

    p_vseip_plat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        plat_vsext |-> pend_out[10]);

    p_timer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vs_timer |-> pend_out[6]);

    p_alias_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && acc_sel == 2'd1) |=> (pend_out[2] == $past(acc_wdata[2])));

    p_hen_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && acc_sel == 2'd2) |=> (en_out == $past(acc_wdata & HIE_MASK)));

    p_zero_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_out & ~HIP_MASK) == '0) && ((en_out & ~HIE_MASK) == '0));

    p_none_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel == 2'd3) |-> (acc_rdata == '0));

    p_en_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_we && acc_sel == 2'd2) |=> $stable(en_out));
endmodule

bind hv_irq_regs hv_irq_regs_chk #(.XLEN(XLEN), .GEILEN(GEILEN), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/hv_irq_regs_bench.sv
`timescale 1ns/1ps
module hv_irq_regs_bench;
    localparam int XLEN   = 64;
    localparam int GEILEN = 6;
    localparam int SEL_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        acc_sel = 2'd0;
    logic              acc_we = 1'b0;
    logic [XLEN-1:0]   acc_wdata = '0;
    logic [XLEN-1:0]   acc_rdata;
    logic [GEILEN-1:0] gext_pend = '0;
    logic [GEILEN-1:0] gext_en = '0;
    logic [SEL_W-1:0]  guest_sel = '0;
    logic              plat_vsext = 1'b0;
    logic              vs_timer = 1'b0;
    logic [XLEN-1:0]   pend_out;
    logic [XLEN-1:0]   en_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Model state
    logic [XLEN-1:0] m_vip = '0;
    logic [XLEN-1:0] m_hie = '0;

    always #2.5 clk = ~clk;

    hv_irq_regs #(.XLEN(XLEN), .GEILEN(GEILEN), .SEL_W(SEL_W)) u_hv_irq_regs (
        .clk(clk), .rst_n(rst_n), .acc_sel(acc_sel), .acc_we(acc_we),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .gext_pend(gext_pend),
        .gext_en(gext_en), .guest_sel(guest_sel), .plat_vsext(plat_vsext),
        .vs_timer(vs_timer), .pend_out(pend_out), .en_out(en_out)
    );

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [XLEN-1:0] exp_hip();
        logic [XLEN-1:0] h;
        logic selbit;
        int s;
        s = int'(guest_sel);
        selbit = (s >= 1 && s <= GEILEN) ? gext_pend[s-1] : 1'b0;
        h = '0;
        h[2]  = m_vip[2];
        h[6]  = m_vip[6] | vs_timer;
        h[10] = m_vip[10] | selbit | plat_vsext;
        h[12] = |(gext_pend & gext_en);
        return h;
    endfunction

    task automatic wr(input logic [1:0] s, input logic [XLEN-1:0] d);
        @(negedge clk);
        acc_sel = s; acc_we = 1'b1; acc_wdata = d;
        @(negedge clk);
        acc_we = 1'b0; acc_wdata = '0;
        case (s)
            2'd0: m_vip = d & XLEN'(16'h0444);
            2'd1: m_vip[2] = d[2];
            2'd2: m_hie = d & XLEN'(16'h1444);
            default: ;
        endcase
    endtask

    task automatic rd(input logic [1:0] s, output logic [XLEN-1:0] v);
        acc_sel = s;
        #1;
        v = acc_rdata;
    endtask

    initial begin
        #900000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [XLEN-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v);
            chk("R1 reset read", v, '0);
        end
        chk("R1 reset pend_out", pend_out, '0);
        chk("R1 reset en_out", en_out, '0);

        // R2 / R9 virtual-pending single-bit sweep
        for (int b = 0; b < XLEN; b++) begin
            wr(2'd0, XLEN'(1) << b);
            rd(2'd0, v);
            chk("R2 vpend readback", v, m_vip);
            chk("R10 pend_out", pend_out, exp_hip());
        end
        // R8 / R9 enable single-bit sweep
        for (int b = 0; b < XLEN; b++) begin
            wr(2'd2, XLEN'(1) << b);
            rd(2'd2, v);
            chk("R8 hen readback", v, m_hie);
            chk("R10 en_out", en_out, m_hie);
        end
        wr(2'd2, '1);
        rd(2'd2, v);
        chk("R8 hen all ones", v, XLEN'(16'h1444));

        // R7 alias and R6/R4/R3 read-only under hip writes
        wr(2'd0, '0);
        wr(2'd1, '1);
        rd(2'd1, v);
        chk("R7 hip write ones", v, exp_hip());
        rd(2'd0, v);
        chk("R7 alias into vpend", v, XLEN'(16'h0004));
        wr(2'd0, XLEN'(16'h0440));
        wr(2'd1, '0);
        rd(2'd0, v);
        chk("R6 hip zero write keeps vpend bits", v, XLEN'(16'h0440));
        rd(2'd1, v);
        chk("R4 hip bits from vpend", v, XLEN'(16'h0440));

        // R9 select 3
        wr(2'd3, '1);
        rd(2'd3, v);
        chk("R9 none select", v, '0);
        rd(2'd0, v);
        chk("R9 none write no effect vpend", v, XLEN'(16'h0440));
        rd(2'd2, v);
        chk("R9 none write no effect hen", v, XLEN'(16'h1444));

        // R6 timer line
        wr(2'd0, '0);
        vs_timer = 1'b1;
        rd(2'd1, v);
        chk("R6 timer sets bit6", v, exp_hip());
        vs_timer = 1'b0;
        rd(2'd1, v);
        chk("R6 timer clear", v, '0);

        // R4 platform line
        plat_vsext = 1'b1;
        rd(2'd1, v);
        chk("R4 platform line", v, XLEN'(16'h0400));
        plat_vsext = 1'b0;

        // R3 all pending/enable pairs
        for (int p = 0; p < (1 << GEILEN); p++) begin
            for (int e = 0; e < (1 << GEILEN); e++) begin
                gext_pend = GEILEN'(p); gext_en = GEILEN'(e); guest_sel = '0;
                #1;
                chk("R3 sgei summary", pend_out, exp_hip());
            end
        end
        gext_en = '0;

        // R5 selector sweep against one-hot and empty patterns
        for (int s = 0; s < (1 << SEL_W); s++) begin
            for (int b = 0; b <= GEILEN; b++) begin
                guest_sel = SEL_W'(s);
                gext_pend = (b == GEILEN) ? '0 : GEILEN'(1) << b;
                rd(2'd1, v);
                chk("R5 selector", v, exp_hip());
            end
        end
        gext_pend = '0; guest_sel = '0;

        // R4 stored bit plus R10
        wr(2'd0, XLEN'(16'h0400));
        rd(2'd1, v);
        chk("R4 stored vseip", v, XLEN'(16'h0400));
        chk("R10 pend_out match", pend_out, v);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule